// File: doc/BRIEF.md
# Multi-Core Placement Conflict Resolver

A shared, banked cache ranks its storage locations by write latency. Each core tends to steer its write-heavy blocks toward the fastest location. When two or more cores do this, their hot blocks can keep evicting each other from that one slot. This block watches for that pattern and steers cores away from it. It counts misses per core over fixed windows of cycles. It also records whether each core reported that its write-heavy data is aiming at the fastest location. When several such cores show rising misses in the same window, it moves one of them to the second-best location. The moved core is picked in rotation.

Each core's placement rank is an override that the cache's placement logic applies when it chooses a write target. Rank 0 means the fastest location. Higher ranks mean slower locations. A core that has been moved and still misses heavily is pushed one rank further per window, up to the slowest location. A core whose misses fall off returns to rank 0.

Top module: `pcr_conflict_resolver`

## Requirements
- R1: After the asynchronous reset is asserted, every rank is 0. The miss counts, the previous-window counts and the contention flags are cleared. The window restarts at its first cycle. The rotation pointer points at core 0.
- R2: A window is WIN_LEN cycles long. A miss on any cycle of the window is counted, including the last cycle. Ranks change only on the clock edge that closes a window, and they hold during the rest of the window.
- R3: A core has grown when its miss count at window close is strictly greater than its count from the previous window. An equal or smaller count is not growth.
- R4: A conflict exists at window close only when at least two cores have both grown and raised their contention input on at least one cycle of that window. A contention pulse is remembered until the window closes.
- R5: On a conflict, the eligible cores are those that grew, contended and sit at rank 0. The first eligible core at or after the rotation pointer, in rising index order with wrap, moves to rank 1. The pointer then moves to the next index after that core. With no eligible core, nothing moves and the pointer keeps its value.
- R6: At window close, a core at a rank above 0 whose miss count exceeds thresh_i moves up one rank. The rank saturates at N_RANKS-1.
- R7: At window close, a core whose miss count is below thresh_i returns to rank 0, unless it is being redirected. A count equal to thresh_i leaves the rank unchanged. The threshold is read at every close.
- R8: A redirect of one core (R5) and a demotion of another core (R6) at the same window close both take effect.
- R9: The rank of core c appears on rank_o bits [c*RANK_W +: RANK_W], where RANK_W = clog2(N_RANKS).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| miss_i | input | N_CORES | Per-core cache miss event, one per cycle |
| contend_i | input | N_CORES | Per-core flag: a write-intensive block targets the fastest write location |
| thresh_i | input | CNT_W | Window miss threshold for demotion and recovery |
| rank_o | output | N_CORES*RANK_W | Per-core placement rank override, 0 = fastest |

## Verification
Redirecting a fresh core to rank 1 and demoting an already-moved core can happen on the same window close. The stimulus provokes this by giving two cores rising misses and contention in one window. One of those cores already sits at rank 1, so it is not eligible. The bench expects that core at rank 2 and the other at rank 1, read from rank_o after that close. The run also checks that the rotation pointer skips the ineligible core, and that a later reset returns the pointer to core 0. This is judged by a window with misses only on its last cycle, where core 0 must be the one redirected.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD,
    ACT_REDIRECT,
    ACT_DEMOTE,
    ACT_RECOVER
  } rank_act_e;
endpackage

// File: rtl/pcr_win_timer.sv
module pcr_win_timer #(
  parameter int unsigned WIN_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic close_o
);
  localparam int unsigned WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

  logic [WIN_W-1:0] win_q;

  assign close_o = (win_q == WIN_W'(WIN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_q <= '0;
    else if (close_o) win_q <= '0;
    else              win_q <= win_q + WIN_W'(1);
  end

  a_r2_close_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |=> !close_o || (WIN_LEN == 1));
endmodule

// File: rtl/pcr_core_tracker.sv
module pcr_core_tracker #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             close_i,
  input  logic             miss_i,
  input  logic             contend_i,
  output logic [CNT_W-1:0] win_cnt_o,
  output logic             grew_o,
  output logic             hot_o
);
  logic [CNT_W-1:0] cnt_q, prev_q;
  logic             seen_q;

  // count includes this cycle's miss, saturating
  assign win_cnt_o = (miss_i && (cnt_q != '1)) ? cnt_q + CNT_W'(1) : cnt_q;
  assign grew_o    = win_cnt_o > prev_q;
  assign hot_o     = seen_q | contend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= '0;
      seen_q <= 1'b0;
    end else if (close_i) begin
      cnt_q  <= '0;
      prev_q <= win_cnt_o;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= win_cnt_o;
      seen_q <= hot_o;
    end
  end

  a_r4_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (contend_i && !close_i) |=> hot_o);
endmodule

// File: rtl/pcr_rr_picker.sv
module pcr_rr_picker #(
  parameter int unsigned N_CORES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [N_CORES-1:0] eligible_i,
  output logic [N_CORES-1:0] pick_o
);
  localparam int unsigned PTR_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  logic [PTR_W-1:0] ptr_q;
  logic             found;
  int unsigned      sel;

  always_comb begin
    found = 1'b0;
    sel   = 0;
    for (int i = 0; i < int'(N_CORES); i++) begin
      int unsigned idx;
      idx = (int'(ptr_q) + i) % N_CORES;
      if (!found && eligible_i[idx]) begin
        found = 1'b1;
        sel   = idx;
      end
    end
  end

  always_comb begin
    pick_o = '0;
    if (en_i && found) pick_o[sel] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ptr_q <= '0;
    else if (en_i && found)   ptr_q <= PTR_W'((sel + 1) % N_CORES);
  end

  a_r5_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pick_o));
  a_r5_pick_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_o & ~eligible_i) == '0);
endmodule

// File: rtl/pcr_rank_cell.sv
module pcr_rank_cell
  import pcr_pkg::*;
#(
  parameter int unsigned N_RANKS = 4,
  parameter int unsigned CNT_W   = 5,
  localparam int unsigned RANK_W = (N_RANKS > 1) ? $clog2(N_RANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              close_i,
  input  logic              redirect_i,
  input  logic [CNT_W-1:0]  win_cnt_i,
  input  logic [CNT_W-1:0]  thresh_i,
  output logic [RANK_W-1:0] rank_o
);
  localparam logic [RANK_W-1:0] RANK_MAX = RANK_W'(N_RANKS - 1);

  logic [RANK_W-1:0] rank_q, rank_d;
  rank_act_e         act;

  always_comb begin
    act = ACT_HOLD;
    if (close_i) begin
      if (rank_q == '0 && redirect_i)                 act = ACT_REDIRECT;
      else if (win_cnt_i < thresh_i)                  act = ACT_RECOVER;
      else if (rank_q != '0 && win_cnt_i > thresh_i)  act = ACT_DEMOTE;
    end
  end

  always_comb begin
    unique case (act)
      ACT_REDIRECT: rank_d = RANK_W'(1);
      ACT_DEMOTE:   rank_d = (rank_q == RANK_MAX) ? rank_q : rank_q + RANK_W'(1);
      ACT_RECOVER:  rank_d = '0;
      default:      rank_d = rank_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rank_q <= '0;
    else         rank_q <= rank_d;
  end

  assign rank_o = rank_q;

  a_r2_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !close_i |=> $stable(rank_q));
  a_r6_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |=> (rank_q == '0) || ({1'b0, rank_q} <= {1'b0, $past(rank_q)} + 1'b1));
  a_r7_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_i && !redirect_i && win_cnt_i < thresh_i) |=> rank_q == '0);
endmodule

// File: rtl/pcr_conflict_resolver.sv
module pcr_conflict_resolver #(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned N_RANKS = 4,
  parameter int unsigned WIN_LEN = 16,
  parameter int unsigned CNT_W   = 5,
  localparam int unsigned RANK_W = (N_RANKS > 1) ? $clog2(N_RANKS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CORES-1:0]        miss_i,
  input  logic [N_CORES-1:0]        contend_i,
  input  logic [CNT_W-1:0]          thresh_i,
  output logic [N_CORES*RANK_W-1:0] rank_o
);
  logic               close;
  logic [N_CORES-1:0] grew, hot, eligible, pick;
  logic [CNT_W-1:0]   win_cnt [N_CORES];
  logic [RANK_W-1:0]  rank    [N_CORES];
  logic               conflict;

  pcr_win_timer #(.WIN_LEN(WIN_LEN)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .close_o(close)
  );

  assign conflict = close && ($countones(grew & hot) >= 2);

  pcr_rr_picker #(.N_CORES(N_CORES)) u_picker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (conflict),
    .eligible_i(eligible),
    .pick_o    (pick)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    pcr_core_tracker #(.CNT_W(CNT_W)) u_trk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .close_i  (close),
      .miss_i   (miss_i[c]),
      .contend_i(contend_i[c]),
      .win_cnt_o(win_cnt[c]),
      .grew_o   (grew[c]),
      .hot_o    (hot[c])
    );

    assign eligible[c] = grew[c] && hot[c] && (rank[c] == '0);

    pcr_rank_cell #(.N_RANKS(N_RANKS), .CNT_W(CNT_W)) u_rank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .close_i   (close),
      .redirect_i(pick[c]),
      .win_cnt_i (win_cnt[c]),
      .thresh_i  (thresh_i),
      .rank_o    (rank[c])
    );

    assign rank_o[c*RANK_W +: RANK_W] = rank[c];

    a_r5_redirect_rank: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pick[c] |=> rank[c] == RANK_W'(1));
    a_r3_pick_needs_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pick[c] |-> grew[c] && hot[c]);
  end
endmodule

// File: tb/tb_pcr_conflict_resolver.sv
module tb_pcr_conflict_resolver;
  localparam int NC = 4;
  localparam int NR = 4;
  localparam int WL = 16;
  localparam int CW = 5;
  localparam int RW = 2;
  localparam int NV = 11;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NC-1:0] miss_i = '0;
  logic [NC-1:0] contend_i = '0;
  logic [CW-1:0] thresh_i = 5'd8;
  logic [NC*RW-1:0] rank_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pcr_conflict_resolver #(.N_CORES(NC), .N_RANKS(NR), .WIN_LEN(WL), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .miss_i(miss_i), .contend_i(contend_i),
    .thresh_i(thresh_i), .rank_o(rank_o)
  );

  // per window: miss count per core, contention mask (pulsed on first cycle), expected ranks
  localparam int MISS [NV][NC] = '{
    '{8, 8, 0, 0}, '{10, 9, 0, 0}, '{12, 10, 0, 0}, '{12, 12, 0, 0},
    '{2, 8, 0, 0}, '{0, 0, 5, 6},  '{0, 0, 0, 7},   '{3, 0, 0, 9},
    '{3, 0, 0, 9}, '{5, 4, 0, 9},  '{6, 5, 0, 0}};
  localparam int CON [NV] = '{3, 3, 0, 0, 0, 12, 8, 9, 15, 0, 3};
  localparam int EXP [NV][NC] = '{
    '{1, 0, 0, 0}, '{2, 1, 0, 0}, '{3, 2, 0, 0}, '{3, 3, 0, 0},
    '{0, 3, 0, 0}, '{0, 0, 1, 0}, '{0, 0, 0, 0}, '{0, 0, 0, 1},
    '{0, 0, 0, 2}, '{0, 0, 0, 3}, '{1, 0, 0, 0}};

  function automatic string tag(int v);
    case (v)
      0: return "R3 R5 first conflict";
      1: return "R8 redirect plus demote";
      2: return "R6 demote both";
      3: return "R6 saturate";
      4: return "R7 recover and equal hold";
      5: return "R5 rotation";
      6: return "R4 single grower";
      7: return "R5 pointer";
      8: return "R3 no growth";
      9: return "R4 no contention";
      default: return "R5 pointer wrap";
    endcase
  endfunction

  task automatic check_ranks(string req, int e0, int e1, int e2, int e3);
    int exp_r [NC];
    exp_r = '{e0, e1, e2, e3};
    for (int c = 0; c < NC; c++) begin
      tests++;
      if (int'(rank_o[c*RW +: RW]) != exp_r[c]) begin
        fails++;
        $display("FAIL %s core %0d rank actual %0d expected %0d", req, c,
                 rank_o[c*RW +: RW], exp_r[c]);
      end
    end
  endtask

  // called at a negedge with window cycle 0 next; returns at negedge after close
  task automatic run_window(int m0, int m1, int m2, int m3, int con, bit late);
    int m [NC];
    logic [NC*RW-1:0] start_ranks;
    m = '{m0, m1, m2, m3};
    start_ranks = rank_o;
    for (int k = 0; k < WL; k++) begin
      for (int c = 0; c < NC; c++)
        miss_i[c] = late ? (k >= WL - m[c]) : (k < m[c]);
      contend_i = (k == 0) ? con[NC-1:0] : '0;
      if (k == WL / 2) begin
        tests++; // R2 hold mid-window
        if (rank_o != start_ranks) begin
          fails++;
          $display("FAIL R2 mid-window rank_o actual %h expected %h", rank_o, start_ranks);
        end
      end
      @(negedge clk);
    end
    miss_i = '0;
    contend_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_ranks("R1 reset state", 0, 0, 0, 0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      run_window(MISS[v][0], MISS[v][1], MISS[v][2], MISS[v][3], CON[v], 1'b0);
      check_ranks(tag(v), EXP[v][0], EXP[v][1], EXP[v][2], EXP[v][3]);
    end

    // R1: asynchronous reset mid-window clears ranks at once
    miss_i = 4'b1111;
    repeat (5) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check_ranks("R1 async reset", 0, 0, 0, 0);
    miss_i = '0;
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 last-cycle miss counted; R1 pointer back at core 0
    run_window(1, 1, 0, 0, 3, 1'b1);
    check_ranks("R2 R1 last-cycle miss, pointer reset", 1, 0, 0, 0);

    // R7 threshold programmable: 10 misses under threshold 12 recovers
    thresh_i = 5'd12;
    run_window(10, 0, 0, 0, 0, 1'b0);
    check_ranks("R7 raised threshold recovers", 0, 0, 0, 0);

    // R9 field position: core 2 redirected shows on bits [5:4]
    run_window(0, 0, 4, 4, 12, 1'b0);
    tests++;
    if (rank_o != 8'b0001_0000) begin
      fails++;
      $display("FAIL R9 rank_o actual %b expected %b", rank_o, 8'b0001_0000);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule